// File: doc/BRIEF.md
# Boot-time configuration loader

This block assembles the configuration byte set of a two-port media converter each time reset is released. On the first clock edge after release it captures the level of five strap inputs and fills a default image from them and from fixed defaults. It then fetches eight consecutive bytes from an external serial EEPROM. Each fetch is a one-byte request/acknowledge handshake, and the bit-level serial master sits outside this block. The fetched bytes replace the defaults only when the first two bytes carry the expected signature and every fetch succeeds. All of the fetched image is applied in a single step, never part of it.

When loading stops, whether by completion, bad signature or a no-acknowledge, the block raises `cfg_done`. It then drops its bus-ownership output so that another controller may use the EEPROM. From that point a management write port may overwrite image bytes 2 to 7. Every field of the image is brought out as a named output.

Top module: `cfg_boot_loader`

## Requirements
- R1: The straps are captured on the first rising clock edge after `rst_n` goes high. Strap changes after that edge have no effect on any output.
- R2: While loading, `rd_req` is high with `rd_addr` stepping 0,1,...,7 in order. Each address is held until `rd_ack` or `rd_nack`, and `rd_nack` wins when both are high.
- R3: Byte 0 must be 55h and byte 1 must be AAh. On a mismatch reading stops, `cfg_done` rises, the defaults stay and `cfg_applied` stays 0.
- R4: When the bytes are applied, byte 2 drives `fwd_bypass` (bit 1), `fwd_cut_thru` (bit 2), `pass_frag` (bit 3), `col16_drop` (bit 4), `backoff_en` (bit 5) and `tp_backpress` (bit 7).
- R5: When the bytes are applied, byte 3 drives `bist_en` (bit 4), `an_limit` (bit 5) and `rx_en` (bit 6).
- R6: When the bytes are applied, byte 6 drives `tp_an_en` (bit 2), `tp_speed100` (bit 3), `tp_full` (bit 4), `tp_fc_en` (bit 5) and `fx_fc_en` (bit 7).
- R7: When the bytes are applied, byte 7 drives `fx_full` (bit 0), `tp_in_thr` (bits 4:3), `tp_out_thr` (bits 6:5) and `lfp_en` (bit 7). Throttle code 0 means full rate and codes 1, 2, 3 mean one, two and three quarters.
- R8: Bytes 4 and 5 give `tp_pages` and `fx_pages`. If their sum is not 240 when applied, both become 120 and `cfg_page_err` is set.
- R9: A `rd_nack` stops reading and sets `cfg_nack_err` and `cfg_done`. No fetched byte is applied.
- R10: `cfg_done` stays high until reset. While it is high, `ee_bus_en` and `rd_req` are low.
- R11: Without an applied EEPROM image the outputs have these values:
  - `fwd_bypass`, `fwd_cut_thru`, `an_limit`, `fx_full` and `lfp_en` follow their straps.
  - `backoff_en`, `tp_backpress`, `bist_en`, `rx_en`, `tp_an_en`, `tp_speed100`, `tp_full`, `tp_fc_en` and `fx_fc_en` are 1.
  - `pass_frag` and `col16_drop` are 0, both throttles are 0, and both page counts are 120.
- R12: After `cfg_done`, a `mgmt_we` to address 2 to 7 replaces that byte from the next cycle on, with no page-sum check. Writes to address 0 or 1 are ignored, and so is any write before `cfg_done`.
- R13: During reset `cfg_done`, `rd_req`, `cfg_applied`, `cfg_nack_err` and `cfg_page_err` are 0 and `ee_bus_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_bypass | input | 1 | Strap: direct converter forwarding |
| strap_cut_thru | input | 1 | Strap: early-forward switching |
| strap_an_limit | input | 1 | Strap: limit advertised abilities |
| strap_fx_full | input | 1 | Strap: fiber full duplex |
| strap_lfp | input | 1 | Strap: link-fault pass-through |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | 3 | Byte address being requested |
| rd_ack | input | 1 | Read completed, `rd_data` valid |
| rd_nack | input | 1 | Read failed, device did not acknowledge |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| ee_bus_en | output | 1 | Loader owns the EEPROM bus |
| mgmt_we | input | 1 | Management byte write strobe |
| mgmt_addr | input | 3 | Management byte address |
| mgmt_wdata | input | 8 | Management write data |
| cfg_done | output | 1 | Loading finished |
| cfg_applied | output | 1 | EEPROM image was applied |
| cfg_nack_err | output | 1 | Load stopped by a no-acknowledge |
| cfg_page_err | output | 1 | Page counts did not sum to 240 |
| fwd_bypass | output | 1 | Converter (unbuffered) forwarding |
| fwd_cut_thru | output | 1 | Early-forward switching |
| pass_frag | output | 1 | Forward short fragments |
| col16_drop | output | 1 | Drop after 16 collisions |
| backoff_en | output | 1 | Back off after collision |
| tp_backpress | output | 1 | Copper-port half-duplex backpressure |
| bist_en | output | 1 | Buffer memory self-test enable |
| an_limit | output | 1 | Restrict negotiated abilities |
| rx_en | output | 1 | Copper-port receive enable |
| tp_pages | output | 8 | Copper-port buffer pages |
| fx_pages | output | 8 | Fiber-port buffer pages |
| tp_an_en | output | 1 | Copper-port auto-negotiation |
| tp_speed100 | output | 1 | Copper-port 100 Mb/s |
| tp_full | output | 1 | Copper-port full duplex |
| tp_fc_en | output | 1 | Copper-port flow control |
| fx_fc_en | output | 1 | Fiber-port flow control |
| fx_full | output | 1 | Fiber full duplex |
| tp_in_thr | output | 2 | Copper ingress throttle code |
| tp_out_thr | output | 2 | Copper egress throttle code |
| lfp_en | output | 1 | Link-fault pass-through enable |

## Verification
The checker watches the handshake and the hand-over on every cycle. It checks that a pending address holds until it is answered, that the bus is released and no request follows once done is high, and that done never falls. It also checks that a committed image always carries page counts summing to 240 and that error flags appear only with done. Whether the right bytes land in the right fields, and whether strap values or fetched data win, can only be shown by the bench's scenarios. The same holds for late strap changes and for writes made during the load or to the signature addresses.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int BYTE_W    = 8;
  localparam int IMG_BYTES = 8;
  localparam int IMG_AW    = $clog2(IMG_BYTES);
  localparam int FIRST_CFG = 2;              // bytes below this are the signature
  localparam int PG_TP_IDX = 4;
  localparam int PG_FX_IDX = 5;

  localparam logic [BYTE_W-1:0] SIG_LO    = 8'h55;
  localparam logic [BYTE_W-1:0] SIG_HI    = 8'hAA;
  localparam logic [BYTE_W-1:0] PAGE_HALF = 8'd120;

  typedef enum logic [1:0] {LD_LATCH, LD_READ, LD_DONE} ld_state_e;

  typedef struct packed {
    logic bypass;
    logic cut_thru;
    logic an_limit;
    logic fx_full;
    logic lfp;
  } strap_t;

  // True when a fetched byte is acceptable at its position.
  function automatic logic sig_byte_ok(input logic [IMG_AW-1:0] addr,
                                       input logic [BYTE_W-1:0] d);
    if (addr == IMG_AW'(0)) return d == SIG_LO;
    if (addr == IMG_AW'(1)) return d == SIG_HI;
    return 1'b1;
  endfunction

  // True when the two page counts add up to the required total.
  function automatic logic pages_balanced(input logic [BYTE_W-1:0] a,
                                          input logic [BYTE_W-1:0] b,
                                          input int total);
    return ({1'b0, a} + {1'b0, b}) == (BYTE_W+1)'(total);
  endfunction

endpackage

// File: rtl/cfg_strap_defaults.sv
module cfg_strap_defaults
  import cfg_loader_pkg::*;
(
  input  strap_t                                  straps,
  output logic [IMG_BYTES-1:FIRST_CFG][BYTE_W-1:0] dflt
);
  always_comb begin
    dflt[2] = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, straps.cut_thru, straps.bypass, 1'b0};
    dflt[3] = {1'b0, 1'b1, straps.an_limit, 1'b1, 4'b1100};
    dflt[PG_TP_IDX] = PAGE_HALF;
    dflt[PG_FX_IDX] = PAGE_HALF;
    dflt[6] = 8'hBC;
    dflt[7] = {straps.lfp, 2'b00, 2'b00, 1'b0, 1'b1, straps.fx_full};
  end
endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
  import cfg_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ack,
  input  logic              rd_nack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [IMG_AW-1:0] rd_addr,
  output logic              ee_bus_en,
  output logic              ld_latch,
  output logic              stage_wr,
  output logic              ld_commit,
  output logic              nack_hit,
  output logic              done
);
  localparam logic [IMG_AW-1:0] LAST = IMG_AW'(IMG_BYTES-1);

  ld_state_e   state;
  logic [IMG_AW-1:0] addr_q;
  logic        got_byte, sig_bad;

  always_comb begin
    ld_latch  = (state == LD_LATCH);
    rd_req    = (state == LD_READ);
    done      = (state == LD_DONE);
    ee_bus_en = !done;
    rd_addr   = addr_q;
    nack_hit  = rd_req && rd_nack;
    got_byte  = rd_req && rd_ack && !rd_nack;
    sig_bad   = got_byte && !sig_byte_ok(addr_q, rd_data);
    stage_wr  = got_byte && (addr_q >= IMG_AW'(FIRST_CFG));
    ld_commit = stage_wr && (addr_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LD_LATCH;
      addr_q <= '0;
    end else begin
      case (state)
        LD_LATCH: begin
          state  <= LD_READ;
          addr_q <= '0;
        end
        LD_READ: begin
          if (nack_hit || sig_bad || ld_commit) state <= LD_DONE;
          else if (got_byte)                    addr_q <= addr_q + IMG_AW'(1);
        end
        default: state <= LD_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_image_regs.sv
module cfg_image_regs
  import cfg_loader_pkg::*;
#(
  parameter int PAGE_TOTAL = 240
)(
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    ld_latch,
  input  logic [IMG_BYTES-1:FIRST_CFG][BYTE_W-1:0] dflt,
  input  logic                                    stage_wr,
  input  logic                                    ld_commit,
  input  logic                                    nack_hit,
  input  logic                                    done,
  input  logic [IMG_AW-1:0]                       rd_addr,
  input  logic [BYTE_W-1:0]                       rd_data,
  input  logic                                    mgmt_we,
  input  logic [IMG_AW-1:0]                       mgmt_addr,
  input  logic [BYTE_W-1:0]                       mgmt_wdata,
  output logic [IMG_BYTES-1:FIRST_CFG][BYTE_W-1:0] img,
  output logic                                    applied,
  output logic                                    nack_err,
  output logic                                    page_err
);
  logic [IMG_BYTES-1:FIRST_CFG][BYTE_W-1:0] stage, merged;
  logic balanced, mgmt_hit;

  always_comb begin
    merged = stage;
    merged[IMG_BYTES-1] = rd_data;
    balanced = pages_balanced(merged[PG_TP_IDX], merged[PG_FX_IDX], PAGE_TOTAL);
    if (!balanced) begin
      merged[PG_TP_IDX] = PAGE_HALF;
      merged[PG_FX_IDX] = PAGE_HALF;
    end
    mgmt_hit = done && mgmt_we && (mgmt_addr >= IMG_AW'(FIRST_CFG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img      <= '0;
      stage    <= '0;
      applied  <= 1'b0;
      nack_err <= 1'b0;
      page_err <= 1'b0;
    end else begin
      if (ld_latch) img <= dflt;
      if (stage_wr && !ld_commit) stage[rd_addr] <= rd_data;
      if (ld_commit) begin
        img      <= merged;
        applied  <= 1'b1;
        page_err <= !balanced;
      end
      if (nack_hit) nack_err <= 1'b1;
      if (mgmt_hit) img[mgmt_addr] <= mgmt_wdata;
    end
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_loader_pkg::*;
#(
  parameter int PAGE_TOTAL = 240
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_bypass,
  input  logic       strap_cut_thru,
  input  logic       strap_an_limit,
  input  logic       strap_fx_full,
  input  logic       strap_lfp,
  output logic       rd_req,
  output logic [2:0] rd_addr,
  input  logic       rd_ack,
  input  logic       rd_nack,
  input  logic [7:0] rd_data,
  output logic       ee_bus_en,
  input  logic       mgmt_we,
  input  logic [2:0] mgmt_addr,
  input  logic [7:0] mgmt_wdata,
  output logic       cfg_done,
  output logic       cfg_applied,
  output logic       cfg_nack_err,
  output logic       cfg_page_err,
  output logic       fwd_bypass,
  output logic       fwd_cut_thru,
  output logic       pass_frag,
  output logic       col16_drop,
  output logic       backoff_en,
  output logic       tp_backpress,
  output logic       bist_en,
  output logic       an_limit,
  output logic       rx_en,
  output logic [7:0] tp_pages,
  output logic [7:0] fx_pages,
  output logic       tp_an_en,
  output logic       tp_speed100,
  output logic       tp_full,
  output logic       tp_fc_en,
  output logic       fx_fc_en,
  output logic       fx_full,
  output logic [1:0] tp_in_thr,
  output logic [1:0] tp_out_thr,
  output logic       lfp_en
);
  strap_t straps;
  logic [IMG_BYTES-1:FIRST_CFG][BYTE_W-1:0] dflt, img;
  logic ld_latch, stage_wr, ld_commit, nack_hit;
  logic unused_rsvd_bits;

  assign straps = '{bypass: strap_bypass, cut_thru: strap_cut_thru,
                    an_limit: strap_an_limit, fx_full: strap_fx_full,
                    lfp: strap_lfp};

  cfg_strap_defaults u_dflt (.straps(straps), .dflt(dflt));

  cfg_read_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .rd_nack(rd_nack),
    .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .ee_bus_en(ee_bus_en), .ld_latch(ld_latch), .stage_wr(stage_wr),
    .ld_commit(ld_commit), .nack_hit(nack_hit), .done(cfg_done)
  );

  cfg_image_regs #(.PAGE_TOTAL(PAGE_TOTAL)) u_img (
    .clk(clk), .rst_n(rst_n), .ld_latch(ld_latch), .dflt(dflt),
    .stage_wr(stage_wr), .ld_commit(ld_commit), .nack_hit(nack_hit),
    .done(cfg_done), .rd_addr(rd_addr), .rd_data(rd_data),
    .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .img(img), .applied(cfg_applied), .nack_err(cfg_nack_err),
    .page_err(cfg_page_err)
  );

  // Field decode; bit positions are fixed by the stored byte layout.
  assign fwd_bypass   = img[2][1];
  assign fwd_cut_thru = img[2][2];
  assign pass_frag    = img[2][3];
  assign col16_drop   = img[2][4];
  assign backoff_en   = img[2][5];
  assign tp_backpress = img[2][7];
  assign bist_en      = img[3][4];
  assign an_limit     = img[3][5];
  assign rx_en        = img[3][6];
  assign tp_pages     = img[PG_TP_IDX];
  assign fx_pages     = img[PG_FX_IDX];
  assign tp_an_en     = img[6][2];
  assign tp_speed100  = img[6][3];
  assign tp_full      = img[6][4];
  assign tp_fc_en     = img[6][5];
  assign fx_fc_en     = img[6][7];
  assign fx_full      = img[7][0];
  assign tp_in_thr    = img[7][4:3];
  assign tp_out_thr   = img[7][6:5];
  assign lfp_en       = img[7][7];

  assign unused_rsvd_bits = ^{img[2][0], img[2][6], img[3][3:0], img[3][7],
                              img[6][1:0], img[6][6], img[7][2:1]};
endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk #(
  parameter int PAGE_TOTAL = 240
)(
  input logic       clk,
  input logic       rst_n,
  input logic       rd_req,
  input logic [2:0] rd_addr,
  input logic       rd_ack,
  input logic       rd_nack,
  input logic       ee_bus_en,
  input logic       cfg_done,
  input logic       cfg_applied,
  input logic       cfg_nack_err,
  input logic       cfg_page_err,
  input logic [7:0] tp_pages,
  input logic [7:0] fx_pages,
  input logic       ld_commit,
  input logic       ld_latch
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack && !rd_nack) |=> (rd_req && $stable(rd_addr)));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (!ee_bus_en && !rd_req));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  // R8
  page_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_commit |=> (({1'b0, tp_pages} + {1'b0, fx_pages}) == 9'(PAGE_TOTAL)));

  // R9
  nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_nack_err |-> (cfg_done && !cfg_applied));

  // R3
  applied_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_applied |-> cfg_done);

  // R8
  page_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_page_err |-> cfg_applied);

  // R1
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_latch |-> (!rd_req && !cfg_done && ee_bus_en));
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(.PAGE_TOTAL(PAGE_TOTAL)) u_chk (.*);

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb;

  typedef struct packed {
    logic [63:0] rom;      // byte i at rom[8*i +: 8]
    logic [4:0]  straps;   // {bypass, cut_thru, an_limit, fx_full, lfp}
    logic [3:0]  nack_at;  // 8 = never
    logic        exp_applied;
    logic        exp_nack;
    logic        exp_perr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{rom: 64'h80BC_7878_5CA0_AA55, straps: 5'b00000, nack_at: 4'd8, exp_applied: 1'b1, exp_nack: 1'b0, exp_perr: 1'b0},
    '{rom: 64'h7914_8C64_201E_AA55, straps: 5'b11111, nack_at: 4'd8, exp_applied: 1'b1, exp_nack: 1'b0, exp_perr: 1'b0},
    '{rom: 64'h4A83_6464_9C02_AA55, straps: 5'b00101, nack_at: 4'd8, exp_applied: 1'b1, exp_nack: 1'b0, exp_perr: 1'b1},
    '{rom: 64'hFFFF_FFFF_FFFF_AA54, straps: 5'b10110, nack_at: 4'd8, exp_applied: 1'b0, exp_nack: 1'b0, exp_perr: 1'b0},
    '{rom: 64'h0000_0000_0000_5555, straps: 5'b01001, nack_at: 4'd8, exp_applied: 1'b0, exp_nack: 1'b0, exp_perr: 1'b0},
    '{rom: 64'h80BC_7878_5CA0_AA55, straps: 5'b11000, nack_at: 4'd0, exp_applied: 1'b0, exp_nack: 1'b1, exp_perr: 1'b0},
    '{rom: 64'h80BC_7878_5CA0_AA55, straps: 5'b00111, nack_at: 4'd5, exp_applied: 1'b0, exp_nack: 1'b1, exp_perr: 1'b0},
    '{rom: 64'h7914_8C64_201E_AA55, straps: 5'b10101, nack_at: 4'd7, exp_applied: 1'b0, exp_nack: 1'b1, exp_perr: 1'b0},
    '{rom: 64'hFFFF_FFFF_FFFF_AA55, straps: 5'b01010, nack_at: 4'd8, exp_applied: 1'b1, exp_nack: 1'b0, exp_perr: 1'b1},
    '{rom: 64'h0000_F000_0000_AA55, straps: 5'b00000, nack_at: 4'd8, exp_applied: 1'b1, exp_nack: 1'b0, exp_perr: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] straps = '0;
  logic rd_ack = 1'b0, rd_nack = 1'b0;
  logic [7:0] rd_data = '0;
  logic mgmt_we = 1'b0;
  logic [2:0] mgmt_addr = '0;
  logic [7:0] mgmt_wdata = '0;

  logic rd_req, ee_bus_en, cfg_done, cfg_applied, cfg_nack_err, cfg_page_err;
  logic [2:0] rd_addr;
  logic fwd_bypass, fwd_cut_thru, pass_frag, col16_drop, backoff_en, tp_backpress;
  logic bist_en, an_limit, rx_en, tp_an_en, tp_speed100, tp_full, tp_fc_en, fx_fc_en;
  logic fx_full, lfp_en;
  logic [7:0] tp_pages, fx_pages;
  logic [1:0] tp_in_thr, tp_out_thr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n),
    .strap_bypass(straps[4]), .strap_cut_thru(straps[3]), .strap_an_limit(straps[2]),
    .strap_fx_full(straps[1]), .strap_lfp(straps[0]),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_nack(rd_nack),
    .rd_data(rd_data), .ee_bus_en(ee_bus_en),
    .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .cfg_done(cfg_done), .cfg_applied(cfg_applied), .cfg_nack_err(cfg_nack_err),
    .cfg_page_err(cfg_page_err),
    .fwd_bypass(fwd_bypass), .fwd_cut_thru(fwd_cut_thru), .pass_frag(pass_frag),
    .col16_drop(col16_drop), .backoff_en(backoff_en), .tp_backpress(tp_backpress),
    .bist_en(bist_en), .an_limit(an_limit), .rx_en(rx_en),
    .tp_pages(tp_pages), .fx_pages(fx_pages),
    .tp_an_en(tp_an_en), .tp_speed100(tp_speed100), .tp_full(tp_full),
    .tp_fc_en(tp_fc_en), .fx_fc_en(fx_fc_en), .fx_full(fx_full),
    .tp_in_thr(tp_in_thr), .tp_out_thr(tp_out_thr), .lfp_en(lfp_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Default byte values written from R11.
  function automatic logic [7:0] dflt_byte(input int i, input logic [4:0] s);
    logic [7:0] b = 8'h00;
    case (i)
      2: begin b[1] = s[4]; b[2] = s[3]; b[5] = 1'b1; b[7] = 1'b1; end
      3: begin b[4] = 1'b1; b[5] = s[2]; b[6] = 1'b1; end
      4, 5: b = 8'd120;
      6: begin b[2] = 1'b1; b[3] = 1'b1; b[4] = 1'b1; b[5] = 1'b1; b[7] = 1'b1; end
      7: begin b[0] = s[1]; b[7] = s[0]; end
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [7:0] exp_byte(input vec_t v, input int i);
    logic [7:0] tp = v.rom[8*4 +: 8];
    logic [7:0] fx = v.rom[8*5 +: 8];
    if (!v.exp_applied) return dflt_byte(i, v.straps);
    if ((i == 4 || i == 5) && (int'(tp) + int'(fx) != 240)) return 8'd120;
    return v.rom[8*i +: 8];
  endfunction

  function automatic int exp_reads(input vec_t v);
    for (int i = 0; i < 8; i++) begin
      if (i == int'(v.nack_at)) return i + 1;
      if (i == 0 && v.rom[7:0] != 8'h55) return 1;
      if (i == 1 && v.rom[15:8] != 8'hAA) return 2;
    end
    return 8;
  endfunction

  task automatic check_fields(input string tag, input logic [7:0] b2, input logic [7:0] b3,
                              input logic [7:0] b4, input logic [7:0] b5,
                              input logic [7:0] b6, input logic [7:0] b7);
    chk({tag, " R4 byte2"}, {24'h0, tp_backpress, 1'b0, backoff_en, col16_drop, pass_frag,
                             fwd_cut_thru, fwd_bypass, 1'b0}, {24'h0, b2 & 8'hBE});
    chk({tag, " R5 byte3"}, {24'h0, 1'b0, rx_en, an_limit, bist_en, 4'h0}, {24'h0, b3 & 8'h70});
    chk({tag, " R8 pages"}, {16'h0, tp_pages, fx_pages}, {16'h0, b4, b5});
    chk({tag, " R6 byte6"}, {24'h0, fx_fc_en, 1'b0, tp_fc_en, tp_full, tp_speed100, tp_an_en, 2'b00},
        {24'h0, b6 & 8'hBC});
    chk({tag, " R7 byte7"}, {24'h0, lfp_en, tp_out_thr, tp_in_thr, 2'b00, fx_full}, {24'h0, b7 & 8'hF9});
  endtask

  task automatic check_image(input string tag, input vec_t v);
    check_fields(tag, exp_byte(v, 2), exp_byte(v, 3), exp_byte(v, 4),
                 exp_byte(v, 5), exp_byte(v, 6), exp_byte(v, 7));
  endtask

  // Reset, release, answer reads from v.rom; optional late strap flip and early write.
  task automatic run_load(input vec_t v, input bit flip, input bit wr_early, output int reads);
    @(negedge clk);
    rst_n = 1'b0;
    straps = v.straps;
    rd_ack = 1'b0; rd_nack = 1'b0; mgmt_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reads = 0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      @(negedge clk);
      rd_ack = 1'b0; rd_nack = 1'b0; mgmt_we = 1'b0;
      if (flip && cyc == 0) straps = ~v.straps;
      if (cfg_done) break;
      if (rd_req) begin
        chk("R2 address order", {29'h0, rd_addr}, reads);
        if (wr_early && reads == 0) begin
          mgmt_we = 1'b1; mgmt_addr = 3'd2; mgmt_wdata = 8'hFF;
        end
        if (int'(v.nack_at) == reads) rd_nack = 1'b1;
        else begin
          rd_ack = 1'b1;
          rd_data = v.rom[8*rd_addr +: 8];
        end
        reads++;
      end
    end
  endtask

  task automatic mgmt_write(input logic [2:0] a, input logic [7:0] d);
    mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
    @(negedge clk);
    mgmt_we = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int reads;
    vec_t v;

    // R13: reset state
    repeat (2) @(negedge clk);
    chk("R13 reset flags", {27'h0, cfg_done, rd_req, cfg_applied, cfg_nack_err, cfg_page_err}, 32'h0);
    chk("R13 reset bus owner", {31'h0, ee_bus_en}, 32'h1);

    // Table of vectors
    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      run_load(v, 1'b0, 1'b0, reads);
      chk($sformatf("R2 R3 R9 read count v%0d", k), reads, exp_reads(v));
      chk($sformatf("R10 done v%0d", k), {30'h0, cfg_done, ee_bus_en}, 32'h2);
      chk($sformatf("R3 R9 R8 flags v%0d", k), {29'h0, cfg_applied, cfg_nack_err, cfg_page_err},
          {29'h0, v.exp_applied, v.exp_nack, v.exp_perr});
      check_image($sformatf("%s v%0d", v.exp_applied ? "applied" : "R11 defaults", k), v);
      repeat (3) @(negedge clk);
      chk($sformatf("R10 no request after done v%0d", k), {30'h0, rd_req, cfg_done}, 32'h1);
    end

    // R1: straps flipped right after the capture edge must not matter
    v = VECS[5];
    run_load(v, 1'b1, 1'b0, reads);
    check_image("R1 late strap change", v);

    // R12: write while loading is ignored
    v = VECS[0];
    run_load(v, 1'b0, 1'b1, reads);
    check_image("R12 write during load", v);

    // R12: writes after done
    mgmt_write(3'd7, 8'h60);
    check_fields("R12 write byte7", exp_byte(v, 2), exp_byte(v, 3), exp_byte(v, 4),
                 exp_byte(v, 5), exp_byte(v, 6), 8'h60);
    mgmt_write(3'd0, 8'hFF);
    mgmt_write(3'd1, 8'h00);
    check_fields("R12 signature addr ignored", exp_byte(v, 2), exp_byte(v, 3), exp_byte(v, 4),
                 exp_byte(v, 5), exp_byte(v, 6), 8'h60);
    mgmt_write(3'd4, 8'd200);
    chk("R12 unchecked page write", {16'h0, tp_pages, fx_pages}, {16'h0, 8'd200, 8'd120});
    chk("R12 page flag untouched", {31'h0, cfg_page_err}, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule